// File: doc/BRIEF.md
# Router Output Port Loopback Controller

This block sits at one output port of a four-port mesh router, between that port's output buffer and the link to the neighbouring router. In normal operation it takes packets from the buffer flit by flit and sends them on the link, pacing each flit on the neighbour's availability line. When the neighbour is unavailable, or when the retry logic asks for it after repeated negative acknowledgements, the controller turns the packet back into the router instead. The looped flits come out on a separate loopback bus, where they re-enter the router as a new packet and are routed through another port. While it does this, the controller raises an occupied flag toward the neighbour and ignores the incoming link.

The block also carries the incoming link toward the router's input stage. Every path through it is one register deep, so a flit spends exactly one clock cycle in the block. A packet crossing a router passes one such stage on arrival and one on departure, which adds two cycles in total. Packet boundaries come from a last-flit marker supplied with each buffer flit. The choice between forwarding and looping is made once, on the first flit of a packet, and then holds until that packet's last flit has left.

The controller is a three-state machine. ST_IDLE means no packet is in progress. ST_FWD means a multi-flit packet is being forwarded. ST_LOOP means a multi-flit packet is being looped back. The transitions are:
- T_HEAD_FWD: ST_IDLE to ST_FWD, taken when a head flit arrives with the neighbour ready and no retry request.
- T_HEAD_LOOP: ST_IDLE to ST_LOOP, taken when a head flit arrives while the neighbour is unavailable or a retry request is present.
- T_FWD_DONE: ST_FWD to ST_IDLE, taken when the last flit is forwarded.
- T_LOOP_DONE: ST_LOOP to ST_IDLE, taken when the last flit is looped.
- T_SINGLE: ST_IDLE to ST_IDLE, taken by a one-flit packet in either direction.

Top module: `loopback_port_ctrl`

## Requirements
- R1: When reset is asserted (rst_n low), the machine returns to ST_IDLE. It also clears link_out_valid, loop_valid, occ_out and rx_valid, and clears any loopback in progress.
- R2: A head flit is forwarded when it is offered (buf_valid=1) in ST_IDLE with nbr_ready=1 and retry_loop=0. In that case buf_take is 1 in the same cycle. In the next cycle link_out_valid=1 and link_out_flit carries that flit.
- R3: In ST_FWD, a flit is taken only in a cycle where both buf_valid and nbr_ready are 1. A cycle with nbr_ready=0 stalls the packet: buf_take=0, and link_out_valid=0 in the next cycle. link_out_valid is never 1 unless nbr_ready was 1 in the cycle before.
- R4: A head flit offered in ST_IDLE with nbr_ready=0 is looped back. buf_take is 1, and in the next cycle loop_valid=1 with loop_flit carrying that flit. link_out_valid and loop_valid are never both 1.
- R5: A head flit offered in ST_IDLE with retry_loop=1 is looped back even when nbr_ready=1. In the next cycle link_out_valid=0, because the flit is never driven to the link.
- R6: Once a loopback has started, every remaining flit of that packet goes to the loopback bus, up to and including the flit marked buf_last=1. This holds even if nbr_ready returns to 1 partway through. During a loopback, a flit is taken whenever buf_valid=1.
- R7: The retry_loop input is ignored after the head flit. In ST_FWD, the packet keeps being forwarded to its last flit whatever retry_loop does.
- R8: occ_out is 1 in every cycle where loop_valid is 1. It is also 1 in every cycle between two flits of the same looped packet, including idle gaps in the buffer. It returns to 0 in the cycle after the last looped flit.
- R9: rx_valid and rx_flit give link_in_valid and link_in_flit one cycle late while no loopback is active. In a cycle where the controller is looping, link input is dropped: rx_valid=0 in the next cycle, which is the cycle where occ_out=1.
- R10: After the last flit of a packet (buf_last=1) is taken, the next offered flit is treated as a new head flit. This also applies to a one-flit packet in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_valid | input | 1 | Output buffer offers a flit |
| buf_last | input | 1 | Offered flit is the last of its packet |
| buf_flit | input | 16 | Offered flit from the output buffer |
| buf_take | output | 1 | Flit is consumed from the buffer this cycle |
| nbr_ready | input | 1 | Neighbour router is available to receive |
| retry_loop | input | 1 | Retry logic requests loopback of the head packet |
| link_out_valid | output | 1 | Request toward the neighbour: link_out_flit is valid |
| link_out_flit | output | 16 | Flit sent toward the neighbour |
| loop_valid | output | 1 | loop_flit is valid |
| loop_flit | output | 16 | Flit turned back into the router input path |
| occ_out | output | 1 | Port occupied by a loopback; the neighbour must not send |
| link_in_valid | input | 1 | Flit arriving from the neighbour is valid |
| link_in_flit | input | 16 | Flit arriving from the neighbour |
| rx_valid | output | 1 | Forwarded input flit is valid |
| rx_flit | output | 16 | Forwarded input flit toward the router |

## Verification
The bench targets these corner cases:
- A neighbour that becomes available in the middle of a looped packet. A design that re-evaluated availability on each flit would split the packet across both outputs.
- A retry request raised while a packet is being forwarded. A design that acted on it would leak flits onto the loopback bus.
- A retry request on a head flit with the neighbour ready. A design that decided too late would drive that flit onto the link for one cycle.
- An idle gap inside a looped packet. A design that tied occ_out to flit activity would let the neighbour send mid-packet.
- Link input arriving during a loopback. A design that did not block it would pass that input through.
- Reset in the middle of a loopback. A design with a stale loop state would keep looping the next packet instead of forwarding it.

// File: rtl/loopctl_pkg.sv
package loopctl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_LOOP = 2'd2
    } lc_state_e;
endpackage

// File: rtl/lc_fsm.sv
module lc_fsm
    import loopctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      buf_valid,
    input  logic      buf_last,
    input  logic      nbr_ready,
    input  logic      retry_loop,
    output logic      buf_take,
    output logic      send_fwd,
    output logic      send_loop,
    output logic      loop_act,
    output logic      occ_out,
    output lc_state_e state_o
);
    lc_state_e state_q, state_d;
    logic      sel_fwd, sel_loop;
    logic      occ_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            occ_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            occ_q   <= loop_act;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        buf_take = 1'b0;
        sel_fwd  = 1'b0;
        sel_loop = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (buf_valid) begin
                    buf_take = 1'b1;
                    if (retry_loop || !nbr_ready) begin
                        sel_loop = 1'b1;                              // T_HEAD_LOOP / T_SINGLE
                        state_d  = buf_last ? ST_IDLE : ST_LOOP;
                    end else begin
                        sel_fwd  = 1'b1;                              // T_HEAD_FWD / T_SINGLE
                        state_d  = buf_last ? ST_IDLE : ST_FWD;
                    end
                end
            end
            ST_FWD: begin
                if (buf_valid && nbr_ready) begin
                    buf_take = 1'b1;
                    sel_fwd  = 1'b1;
                    if (buf_last) state_d = ST_IDLE;                  // T_FWD_DONE
                end
            end
            ST_LOOP: begin
                sel_loop = 1'b1;
                if (buf_valid) begin
                    buf_take = 1'b1;
                    if (buf_last) state_d = ST_IDLE;                  // T_LOOP_DONE
                end
            end
            default: state_d = ST_IDLE;
        endcase
        send_fwd  = buf_take && sel_fwd;
        send_loop = buf_take && sel_loop;
        loop_act  = (state_q == ST_LOOP) || send_loop;
    end

    assign occ_out = occ_q;
    assign state_o = state_q;

    AST_LOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && !(buf_valid && buf_last)) |=> (state_q == ST_LOOP)); // R6
    AST_OCC_IN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |=> occ_q); // R8
    AST_FWD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FWD && !(buf_take && buf_last)) |=> (state_q == ST_FWD)); // R7
endmodule

// File: rtl/lc_egress.sv
module lc_egress #(
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_fwd,
    input  logic              send_loop,
    input  logic [FLIT_W-1:0] buf_flit,
    output logic              link_out_valid,
    output logic [FLIT_W-1:0] link_out_flit,
    output logic              loop_valid,
    output logic [FLIT_W-1:0] loop_flit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_out_valid <= 1'b0;
            loop_valid     <= 1'b0;
            link_out_flit  <= '0;
            loop_flit      <= '0;
        end else begin
            link_out_valid <= send_fwd;
            loop_valid     <= send_loop;
            if (send_fwd)  link_out_flit <= buf_flit;
            if (send_loop) loop_flit     <= buf_flit;
        end
    end

    AST_ONE_EGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({link_out_valid, loop_valid})); // R4
endmodule

// File: rtl/lc_ingress.sv
module lc_ingress #(
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block,
    input  logic              link_in_valid,
    input  logic [FLIT_W-1:0] link_in_flit,
    output logic              rx_valid,
    output logic [FLIT_W-1:0] rx_flit
);
    logic accept;
    assign accept = link_in_valid && !block;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_flit  <= '0;
        end else begin
            rx_valid <= accept;
            if (accept) rx_flit <= link_in_flit;
        end
    end
endmodule

// File: rtl/loopback_port_ctrl.sv
module loopback_port_ctrl
    import loopctl_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_valid,
    input  logic              buf_last,
    input  logic [FLIT_W-1:0] buf_flit,
    output logic              buf_take,
    input  logic              nbr_ready,
    input  logic              retry_loop,
    output logic              link_out_valid,
    output logic [FLIT_W-1:0] link_out_flit,
    output logic              loop_valid,
    output logic [FLIT_W-1:0] loop_flit,
    output logic              occ_out,
    input  logic              link_in_valid,
    input  logic [FLIT_W-1:0] link_in_flit,
    output logic              rx_valid,
    output logic [FLIT_W-1:0] rx_flit
);
    logic      send_fwd, send_loop, loop_act;
    lc_state_e state;

    lc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_valid  (buf_valid),
        .buf_last   (buf_last),
        .nbr_ready  (nbr_ready),
        .retry_loop (retry_loop),
        .buf_take   (buf_take),
        .send_fwd   (send_fwd),
        .send_loop  (send_loop),
        .loop_act   (loop_act),
        .occ_out    (occ_out),
        .state_o    (state)
    );

    lc_egress #(.FLIT_W(FLIT_W)) u_egress (
        .clk            (clk),
        .rst_n          (rst_n),
        .send_fwd       (send_fwd),
        .send_loop      (send_loop),
        .buf_flit       (buf_flit),
        .link_out_valid (link_out_valid),
        .link_out_flit  (link_out_flit),
        .loop_valid     (loop_valid),
        .loop_flit      (loop_flit)
    );

    lc_ingress #(.FLIT_W(FLIT_W)) u_ingress (
        .clk           (clk),
        .rst_n         (rst_n),
        .block         (loop_act),
        .link_in_valid (link_in_valid),
        .link_in_flit  (link_in_flit),
        .rx_valid      (rx_valid),
        .rx_flit       (rx_flit)
    );

    AST_FWD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        link_out_valid |-> $past(nbr_ready)); // R3
    AST_RETRY_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && buf_valid && retry_loop) |=> !link_out_valid); // R5
    AST_LOOP_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        loop_valid |-> occ_out); // R8
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !occ_out); // R9
endmodule

// File: tb/loopback_port_ctrl_test.sv
module loopback_port_ctrl_test;
    localparam int W = 16;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_valid = 1'b0, buf_last = 1'b0, nbr_ready = 1'b0, retry_loop = 1'b0;
    logic          link_in_valid = 1'b0;
    logic [W-1:0]  buf_flit = '0, link_in_flit = '0;
    logic          buf_take, link_out_valid, loop_valid, occ_out, rx_valid;
    logic [W-1:0]  link_out_flit, loop_flit, rx_flit;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    loopback_port_ctrl #(.FLIT_W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .buf_valid(buf_valid), .buf_last(buf_last), .buf_flit(buf_flit), .buf_take(buf_take),
        .nbr_ready(nbr_ready), .retry_loop(retry_loop),
        .link_out_valid(link_out_valid), .link_out_flit(link_out_flit),
        .loop_valid(loop_valid), .loop_flit(loop_flit), .occ_out(occ_out),
        .link_in_valid(link_in_valid), .link_in_flit(link_in_flit),
        .rx_valid(rx_valid), .rx_flit(rx_flit)
    );

    // {bv, bl, rt, nr, lv, e_take, e_lov, e_lpv, e_occ, e_rxv}
    localparam logic [9:0] VEC [NV] = '{
        10'b00001_00001,  // 0 idle, link in passes
        10'b10010_11000,  // 1 head fwd
        10'b10001_00001,  // 2 fwd stall, nbr busy
        10'b11110_11000,  // 3 fwd last, retry ignored
        10'b10111_10110,  // 4 head loop by retry, link in dropped
        10'b00011_00010,  // 5 loop gap, nbr ready again
        10'b10010_10110,  // 6 loop middle
        10'b11001_10110,  // 7 loop last
        10'b00001_00001,  // 8 idle again
        10'b11000_10110,  // 9 one-flit loop, nbr busy
        10'b11011_11001,  // 10 one-flit fwd
        10'b00000_00000   // 11 quiet
    };

    function automatic string vtag(int i);
        case (i)
            0, 8:    return "R9";
            1:       return "R2";
            2:       return "R3";
            3:       return "R7";
            4:       return "R5";
            5, 6, 7: return "R6/R8";
            9:       return "R4/R10";
            10:      return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        buf_valid = 1'b1; link_in_valid = 1'b1; nbr_ready = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "link_out_valid", link_out_valid, 0);
        chk("R1", "loop_valid", loop_valid, 0);
        chk("R1", "occ_out", occ_out, 0);
        chk("R1", "rx_valid", rx_valid, 0);
        @(negedge clk);
        buf_valid = 1'b0; link_in_valid = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {buf_valid, buf_last, retry_loop, nbr_ready, link_in_valid} = VEC[i][9:5];
            buf_flit     = W'(16'hB000 + i);
            link_in_flit = W'(16'h5000 + i);
            #1;
            chk(vtag(i), "buf_take", buf_take, VEC[i][4]);
            @(posedge clk);
            #1;
            chk(vtag(i), "link_out_valid", link_out_valid, VEC[i][3]);
            chk(vtag(i), "loop_valid", loop_valid, VEC[i][2]);
            chk(vtag(i), "occ_out", occ_out, VEC[i][1]);
            chk(vtag(i), "rx_valid", rx_valid, VEC[i][0]);
            if (VEC[i][3]) chk(vtag(i), "link_out_flit", link_out_flit, 16'hB000 + i);
            if (VEC[i][2]) chk(vtag(i), "loop_flit", loop_flit, 16'hB000 + i);
            if (VEC[i][0]) chk(vtag(i), "rx_flit", rx_flit, 16'h5000 + i);
        end

        // R1: reset in the middle of a loopback clears the loop state
        @(negedge clk);
        buf_valid = 1'b1; buf_last = 1'b0; retry_loop = 1'b1; nbr_ready = 1'b1;
        link_in_valid = 1'b0; buf_flit = 16'hC001;
        @(posedge clk);
        #1;
        chk("R8", "occ_out loop start", occ_out, 1);
        @(negedge clk);
        buf_valid = 1'b0; retry_loop = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "occ_out async reset", occ_out, 0);
        chk("R1", "loop_valid async reset", loop_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        buf_valid = 1'b1; buf_last = 1'b1; nbr_ready = 1'b1; buf_flit = 16'hC002;
        #1;
        chk("R1", "buf_take after reset", buf_take, 1);
        @(posedge clk);
        #1;
        chk("R1", "forward after reset", link_out_valid, 1);
        chk("R1", "no loop after reset", loop_valid, 0);
        chk("R1", "flit after reset", link_out_flit, 16'hC002);
        chk("R1", "occ after reset", occ_out, 0);
        @(negedge clk);
        buf_valid = 1'b0; buf_last = 1'b0;
        @(posedge clk);
        #1;
        chk("R10", "link_out_valid idle", link_out_valid, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule